// File: doc/BRIEF.md
# ECC Check-Byte Fault Injector

This block sits between a SECDED encoder and the memory on the write path of a store that keeps 64 data bits and 8 check bits per word. It passes every write beat through one register stage. When software has armed it, it XORs a chosen 8-bit pattern into the check byte of the next beat before that byte reaches the memory. Because only the check byte is corrupted, one mechanism can produce either kind of fault. A pattern equal to a single column of the parity-check matrix makes a correctable error that looks like a flip of that data bit. A pattern of one bit makes a correctable check-bit error. A pattern of two bits makes an uncorrectable error.

Software reaches the block through a 32-bit word-addressed register port. The control register holds the pattern, a correction-writeback enable and a one-shot arm bit. The status register shows whether a write is in flight, so software can arm only when the path is quiet. A third, write-only selection register builds the pattern in hardware from an error kind, a location and a bit index, and rejects indices that are out of range. The writeback enable is driven out to the read-correction logic. When it is set, a read that corrects the injected error writes the repaired word back.

Top module: `ecc_check_injector`

## Requirements
- R1: After reset the control register (address 0) reads 0, the status register (address 1) reads 0, `memValid` is 0 and `corrWritebackEn` is 0.
- R2: A beat presented with `inValid` high appears at the memory side one cycle later, with `memValid` high and data and address unchanged. No beat appears in a cycle after one with `inValid` low.
- R3: Control register layout: pattern in bits [23:16], writeback enable at bit 24, arm at bit 8. All other bits read 0. Address 2 (selection) and address 3 read 0.
- R4: While the arm bit is 0, an accepted beat's check byte is stored unchanged.
- R5: While the arm bit is 1, the next accepted beat stores its check byte XORed with the pattern. The arm bit clears at that same clock edge, so only one beat is modified.
- R6: The pattern and the writeback enable keep their values when the arm bit clears. `corrWritebackEn` always equals control bit 24.
- R7: Status bit 0 (busy) reads 1 in a cycle where a beat is presented or a beat sits in the output stage, and 0 otherwise.
- R8: A selection write (address 2: index in [7:0], bit 8 = check-bit location, bit 9 = uncorrectable, bit 10 = arm) with bits 9 and 8 clear and index i at most 63 loads pattern column i and sets writeback enable. Column i is the i-th 8-bit value, counted from 0, in the list of all weight-3 values in ascending order followed by all weight-5 values in ascending order.
- R9: A selection write with bit 9 clear, bit 8 set and index j at most 7 loads pattern 1 << j and sets writeback enable.
- R10: A selection write with bit 9 set loads pattern 0x03 and clears writeback enable, whatever the index and location.
- R11: A selection write with bit 9 clear and an index above 63 (data) or above 7 (check) leaves the whole control register, arm bit included, unchanged.
- R12: An accepted selection write sets the arm bit when its bit 10 is 1. When bit 10 is 0, the arm bit keeps its prior value, apart from clearing on a beat in that cycle.
- R13: When a control write and an armed beat fall in the same cycle, the beat uses the old pattern and the written value is what the register holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| inValid | input | 1 | Write beat present from the encoder |
| inAddr | input | ADDR_W | Beat address |
| inData | input | DATA_W | Beat data |
| inCheck | input | CHK_W | Encoded check byte |
| memValid | output | 1 | Beat to memory valid |
| memAddr | output | ADDR_W | Beat address to memory |
| memData | output | DATA_W | Beat data to memory |
| memCheck | output | CHK_W | Check byte to memory, possibly corrupted |
| corrWritebackEn | output | 1 | Enables writeback of corrected reads |

## Verification
The bench builds the block with its defaults: 64 data bits, 8 check bits and 32 address bits. These give the full column table, so the selection path can be exercised at data indices 0, 37 and 63 and rejected at 64, and at check indices 0 and 7 and rejected at 8. With these widths the one-shot arm can be checked against back-to-back beats. Writes that land in the same cycle as an armed beat are covered, and so is a busy read taken while a beat is in flight.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

  localparam int REG_W     = 32;
  localparam int PAT_LSB   = 16;
  localparam int WB_BIT    = 24;
  localparam int ARM_BIT   = 8;
  localparam int BUSY_BIT  = 0;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_PICK = 2'd2;

  // selection word fields
  localparam int PICK_IDX_W   = 8;
  localparam int PICK_LOC_BIT = 8;
  localparam int PICK_UE_BIT  = 9;
  localparam int PICK_ARM_BIT = 10;
  localparam int PICK_W       = 11;

  localparam logic [7:0] UNCORR_PATTERN = 8'h03;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic       take;
    logic       inject;
    logic [7:0] mask;
  } beatStrobe_t;

  // Column idx of a Hsiao-style check matrix: weight-3 codes ascending,
  // then weight-5 codes ascending.
  function automatic logic [7:0] checkColumn(input int unsigned idx);
    int unsigned seen;
    logic [7:0]  res;
    seen = 0;
    res  = '0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 0; v < 256; v++) begin
        if ($countones(8'(v)) == w) begin
          if (seen == idx) res = 8'(v);
          seen++;
        end
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/inj_pattern_gen.sv
module inj_pattern_gen
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8
) (
  input  logic [PICK_W-1:0] pickWord,
  output logic              pickOk,
  output logic [CHK_W-1:0]  pickPattern,
  output logic              pickWbEn,
  output logic              pickArm
);

  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CIDX_W = $clog2(CHK_W);

  logic [CHK_W-1:0] colTable [DATA_W];

  for (genvar g = 0; g < DATA_W; g++) begin : g_col
    assign colTable[g] = CHK_W'(checkColumn(g));
  end

  logic [PICK_IDX_W-1:0] idx;
  logic                  onCheck;
  logic                  uncorr;

  assign idx     = pickWord[PICK_IDX_W-1:0];
  assign onCheck = pickWord[PICK_LOC_BIT];
  assign uncorr  = pickWord[PICK_UE_BIT];
  assign pickArm = pickWord[PICK_ARM_BIT];

  always_comb begin
    pickOk      = 1'b0;
    pickPattern = '0;
    pickWbEn    = 1'b0;
    if (uncorr) begin
      pickOk      = 1'b1;
      pickPattern = CHK_W'(UNCORR_PATTERN);
      pickWbEn    = 1'b0;
    end else if (onCheck) begin
      pickOk      = (32'(idx) < CHK_W);
      pickPattern = CHK_W'(1) << idx[CIDX_W-1:0];
      pickWbEn    = 1'b1;
    end else begin
      pickOk      = (32'(idx) < DATA_W);
      pickPattern = colTable[idx[IDX_W-1:0]];
      pickWbEn    = 1'b1;
    end
  end

endmodule

// File: rtl/inj_ctrl.sv
module inj_ctrl
  import ecc_inj_pkg::*;
#(
  parameter int CHK_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             inValid,
  input  logic             stageValid,
  input  logic             pickOk,
  input  logic [CHK_W-1:0] pickPattern,
  input  logic             pickWbEn,
  input  logic             pickArm,
  output beatStrobe_t      strobe,
  output logic             wbEnOut
);

  logic [CHK_W-1:0] patternQ;
  logic             wbEnQ;
  logic             forceQ;
  logic             ctrlWr;
  logic             pickWr;
  logic             busy;
  logic             unusedWrBits;

  assign unusedWrBits = ^{regWrData[REG_W-1:WB_BIT+1],
                          regWrData[PAT_LSB-1:ARM_BIT+1],
                          regWrData[ARM_BIT-1:0]};

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
  assign pickWr = regWrEn && (regAddr == ADDR_PICK) && pickOk;
  assign busy   = inValid || stageValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patternQ <= '0;
      wbEnQ    <= 1'b0;
      forceQ   <= 1'b0;
    end else if (ctrlWr) begin
      patternQ <= regWrData[PAT_LSB +: CHK_W];
      wbEnQ    <= regWrData[WB_BIT];
      forceQ   <= regWrData[ARM_BIT];
    end else if (pickWr) begin
      patternQ <= pickPattern;
      wbEnQ    <= pickWbEn;
      forceQ   <= pickArm || (forceQ && !inValid);
    end else if (inValid && forceQ) begin
      forceQ   <= 1'b0;
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.take   = inValid;
    strobe.inject = inValid && forceQ;
    strobe.mask   = 8'(patternQ);
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[PAT_LSB +: CHK_W] = patternQ;
        regRdData[WB_BIT]           = wbEnQ;
        regRdData[ARM_BIT]          = forceQ;
      end
      ADDR_STAT: regRdData[BUSY_BIT] = busy;
      default:   regRdData = '0;
    endcase
  end

  assign wbEnOut = wbEnQ;

endmodule

// File: rtl/inj_datapath.sv
module inj_datapath
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  beatStrobe_t       strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [CHK_W-1:0]  inCheck,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [CHK_W-1:0]  memCheck
);

  logic [CHK_W-1:0] xorMask;

  assign xorMask = strobe.inject ? strobe.mask[CHK_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
      memCheck <= '0;
    end else begin
      memValid <= strobe.take;
      if (strobe.take) begin
        memAddr  <= inAddr;
        memData  <= inData;
        memCheck <= inCheck ^ xorMask;
      end
    end
  end

endmodule

// File: rtl/ecc_check_injector.sv
module ecc_check_injector
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [CHK_W-1:0]  inCheck,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [CHK_W-1:0]  memCheck,
  output logic              corrWritebackEn
);

  beatStrobe_t      strobe;
  logic             pickOk;
  logic [CHK_W-1:0] pickPattern;
  logic             pickWbEn;
  logic             pickArm;

  inj_pattern_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) patI (
    .pickWord    (regWrData[PICK_W-1:0]),
    .pickOk      (pickOk),
    .pickPattern (pickPattern),
    .pickWbEn    (pickWbEn),
    .pickArm     (pickArm)
  );

  inj_ctrl #(.CHK_W(CHK_W)) ctrlI (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .inValid     (inValid),
    .stageValid  (memValid),
    .pickOk      (pickOk),
    .pickPattern (pickPattern),
    .pickWbEn    (pickWbEn),
    .pickArm     (pickArm),
    .strobe      (strobe),
    .wbEnOut     (corrWritebackEn)
  );

  inj_datapath #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ADDR_W(ADDR_W)) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inAddr   (inAddr),
    .inData   (inData),
    .inCheck  (inCheck),
    .memValid (memValid),
    .memAddr  (memAddr),
    .memData  (memData),
    .memCheck (memCheck)
  );

endmodule

// File: rtl/ecc_check_injector_chk.sv
module ecc_check_injector_chk
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic              pickUncorr,
  input logic [31:0]       regRdData,
  input logic              inValid,
  input logic [ADDR_W-1:0] inAddr,
  input logic [DATA_W-1:0] inData,
  input logic [CHK_W-1:0]  inCheck,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic [CHK_W-1:0]  memCheck,
  input logic              corrWritebackEn,
  input logic              forceQ,
  input logic [CHK_W-1:0]  patternQ
);

  p_beat_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> memValid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !memValid);

  p_data_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (memData == $past(inData) && memAddr == $past(inAddr)));

  p_check_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !forceQ) |=> memCheck == $past(inCheck));

  p_check_inject_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && forceQ) |=> memCheck == ($past(inCheck) ^ $past(patternQ)));

  p_arm_oneshot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && forceQ && !regWrEn) |=> !forceQ);

  p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(corrWritebackEn));

  p_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STAT && (inValid || memValid)) |-> regRdData[BUSY_BIT]);

  p_uncorr_wb_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_PICK && pickUncorr) |=> !corrWritebackEn);

endmodule

bind ecc_check_injector ecc_check_injector_chk #(
  .DATA_W(DATA_W), .CHK_W(CHK_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk             (clk),
  .rstN            (rstN),
  .regWrEn         (regWrEn),
  .regAddr         (regAddr),
  .pickUncorr      (regWrData[9]),
  .regRdData       (regRdData),
  .inValid         (inValid),
  .inAddr          (inAddr),
  .inData          (inData),
  .inCheck         (inCheck),
  .memValid        (memValid),
  .memAddr         (memAddr),
  .memData         (memData),
  .memCheck        (memCheck),
  .corrWritebackEn (corrWritebackEn),
  .forceQ          (ctrlI.forceQ),
  .patternQ        (ctrlI.patternQ)
);

// File: tb/ecc_check_injector_tb_top.sv
module ecc_check_injector_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        inValid = 1'b0;
  logic [31:0] inAddr = '0;
  logic [63:0] inData = '0;
  logic [7:0]  inCheck = '0;
  logic        memValid;
  logic [31:0] memAddr;
  logic [63:0] memData;
  logic [7:0]  memCheck;
  logic        corrWritebackEn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [7:0]  mPat = '0;
  bit          mWb = 0;
  bit          mArm = 0;
  bit          eValid = 0;
  bit          eInj = 0;
  logic [31:0] eAddr = '0;
  logic [63:0] eData = '0;
  logic [7:0]  eCheck = '0;

  always #5 clk = ~clk;

  ecc_check_injector dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .inValid(inValid),
    .inAddr(inAddr), .inData(inData), .inCheck(inCheck),
    .memValid(memValid), .memAddr(memAddr), .memData(memData),
    .memCheck(memCheck), .corrWritebackEn(corrWritebackEn)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // i-th entry of weight-3 codes ascending, then weight-5 codes ascending
  function automatic logic [7:0] column(int i);
    int n = 0;
    logic [7:0] r = '0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 0; v < 256; v++) begin
        int ones = 0;
        for (int b = 0; b < 8; b++) ones += (v >> b) & 1;
        if (ones == w) begin
          if (n == i) r = 8'(v);
          n++;
        end
      end
    return r;
  endfunction

  // one clock with the given stimulus; compares beat outputs afterwards
  task automatic cyc(bit wv, logic [1:0] wa, logic [31:0] wd,
                     bit bv, logic [63:0] bd, logic [7:0] bc);
    int idx;
    bit ok;
    logic [7:0] p;
    bit wb;
    regWrEn = wv; regAddr = wa; regWrData = wd;
    inValid = bv; inData = bd; inCheck = bc; inAddr = bd[31:0] ^ 32'h1357_9bdf;
    eValid = bv;
    eInj   = bv && mArm;
    eData  = bd;
    eAddr  = inAddr;
    eCheck = bc ^ (eInj ? mPat : 8'h00);
    if (wv && wa == 2'd0) begin
      mPat = wd[23:16]; mWb = wd[24]; mArm = wd[8];
    end else begin
      idx = int'(wd[7:0]);
      ok = 1; p = '0; wb = 1;
      if (wd[9]) begin p = 8'h03; wb = 0; end
      else if (wd[8]) begin ok = idx < 8; if (ok) p = 8'(1 << idx); end
      else begin ok = idx < 64; if (ok) p = column(idx); end
      if (wv && wa == 2'd2 && ok) begin
        mPat = p; mWb = wb; mArm = wd[10] || (mArm && !bv);
      end else if (bv && mArm) mArm = 0;
    end
    @(posedge clk);
    @(negedge clk);
    regWrEn = 0; inValid = 0;
    check(memValid == eValid, "R2 valid", 64'(memValid), 64'(eValid));
    if (eValid) begin
      check(memData == eData && memAddr == eAddr, "R2 data/addr", memData, eData);
      check(memCheck == eCheck, eInj ? "R5 injected check" : "R4 clean check",
            64'(memCheck), 64'(eCheck));
    end
    check(corrWritebackEn == mWb, "R6 writeback output", 64'(corrWritebackEn), 64'(mWb));
  endtask

  task automatic rd(logic [1:0] a, string req);
    logic [31:0] exp;
    regAddr = a;
    #1;
    exp = '0;
    if (a == 2'd0) begin exp[23:16] = mPat; exp[24] = mWb; exp[8] = mArm; end
    else if (a == 2'd1) exp[0] = inValid || eValid;
    check(regRdData == exp, req, 64'(regRdData), 64'(exp));
  endtask

  task automatic idle(); cyc(0, 2'd0, '0, 0, '0, '0); endtask
  task automatic beat(logic [63:0] d, logic [7:0] c); cyc(0, 2'd0, '0, 1, d, c); endtask
  task automatic pick(logic [31:0] w); cyc(1, 2'd2, w, 0, '0, '0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(2'd0, "R1 ctrl after reset");
    rd(2'd1, "R1 status after reset");
    check(!memValid && !corrWritebackEn, "R1 outputs after reset",
          64'({memValid, corrWritebackEn}), 64'(0));

    // R2 R4 clean beats with several patterns
    beat(64'h0123_4567_89ab_cdef, 8'h5c);
    beat(64'hffff_ffff_ffff_ffff, 8'hff);
    idle();
    beat(64'h8000_0000_0000_0001, 8'h00);
    idle();

    // R3 control write with junk bits set
    cyc(1, 2'd0, 32'hE15A_F3FF, 0, '0, '0);
    rd(2'd0, "R3 ctrl readback");
    rd(2'd2, "R3 selection reads zero");
    rd(2'd3, "R3 unused address reads zero");
    idle();
    rd(2'd0, "R5 arm holds while idle");
    // R5 back-to-back: first modified, second clean
    beat(64'hdead_beef_cafe_f00d, 8'h33);
    beat(64'h1111_2222_3333_4444, 8'h33);
    rd(2'd0, "R6 pattern and writeback kept");

    // R7 busy
    rd(2'd1, "R7 busy with beat in stage");
    idle();
    rd(2'd1, "R7 idle not busy");
    inValid = 1;
    rd(2'd1, "R7 busy on presented beat");
    beat(64'h0f0f_0f0f_0f0f_0f0f, 8'h81);

    // R8 data-bit columns, armed
    for (int k = 0; k < 3; k++) begin
      int i = (k == 0) ? 0 : (k == 1) ? 37 : 63;
      pick(32'h0000_0400 | 32'(i));
      rd(2'd0, "R8 data column loaded");
      check(regRdData[23:16] == column(i), "R8 column value",
            64'(regRdData[23:16]), 64'(column(i)));
      beat(64'(i) * 64'h0101_0101_0101_0101, 8'h6a);
    end

    // R9 check-bit patterns
    pick(32'h0000_0507);
    rd(2'd0, "R9 check bit 7");
    beat(64'h2, 8'h00);
    pick(32'h0000_0500);
    rd(2'd0, "R9 check bit 0");
    beat(64'h3, 8'h01);

    // R10 uncorrectable, index ignored
    pick(32'h0000_07C8);
    rd(2'd0, "R10 uncorrectable pattern");
    beat(64'h4, 8'hf0);

    // R11 rejected indices; set a known state first
    cyc(1, 2'd0, 32'h01A5_0100, 0, '0, '0);
    pick(32'h0000_0440);
    rd(2'd0, "R11 data index 64 rejected");
    pick(32'h0000_0508);
    rd(2'd0, "R11 check index 8 rejected");
    beat(64'h5, 8'h0f);

    // R12 selection without arm keeps prior arm state
    pick(32'h0000_0005);
    rd(2'd0, "R12 no arm stays clear");
    beat(64'h6, 8'h10);
    cyc(1, 2'd0, 32'h0000_0100, 0, '0, '0);
    pick(32'h0000_0103);
    rd(2'd0, "R12 no arm keeps set");
    beat(64'h7, 8'h20);
    rd(2'd0, "R12 arm consumed");

    // R13 control write in same cycle as armed beat
    cyc(1, 2'd0, 32'h0011_0100, 0, '0, '0);
    cyc(1, 2'd0, 32'h0122_0100, 1, 64'h8, 8'h44);
    rd(2'd0, "R13 written value held");
    beat(64'h9, 8'h44);
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule